// File: doc/BRIEF.md
# Random-Address Ping-Pong Gather Buffer

This block collects operand words from a small two-bank on-chip memory at pseudo-random addresses and passes them, in gather order, to a slow compute engine downstream. A 16-bit linear feedback shift register supplies two addresses per step. When both addresses land in the same bank, the single read port of that bank serves them in two successive cycles instead of one.

Two 8-word buffers swap roles. One is filled from memory while the other is drained by the consumer through a valid/ready handshake. The consumer therefore waits on memory only for the very first buffer. After that, each fill finishes behind the consumer's own work. The memory model is held inside the block and has no write port. Its contents are set on reset from a fixed function of the address.

Top module: `rga_pingpong_gather`

## Requirements
- R1: The memory holds 32 words, with bank = address bit 0 and in-bank index = address bits 4:1. The word at address a is the low 16 bits of (a * 0x9E37) XOR 0x5A5A.
- R2: The address generator is a 16-bit shift register that shifts left. Its new bit 0 is bit15 ^ bit13 ^ bit12 ^ bit10, and its reset value is 0xACE1. Each step yields a first address from bits 4:0 and a second address from bits 15:11. It advances only after both addresses of the current step have been served.
- R3: If the two addresses of a step lie in different banks, both words are written to the filling buffer in one cycle. If they share a bank, the first address is served in one cycle and the second in the next. In both cases the first address's word comes before the second's in the output stream.
- R4: `conflict_count` rises by exactly one for each step whose two addresses share a bank, and by no more than one per cycle.
- R5: Buffer A is filled first after reset, and the buffers then alternate. The consumer receives every gathered word exactly once, in gather order.
- R6: `out_valid` is high only while the consume buffer is full and not fully read. After reset it first goes high one cycle after the eighth word has been written.
- R7: The buffers swap only when the filling buffer holds 8 words and the consume buffer has been fully read. While both buffers are full, no further gathering takes place, so `conflict_count` stays frozen.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: When the consumer takes 16 or more cycles over a buffer, the next buffer is presented one cycle after the last word of the previous buffer is accepted.
- R10: During and right after reset, `out_valid` is low and `conflict_count` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| out_valid | output | 1 | Consume buffer holds an unread word |
| out_ready | input | 1 | Consumer accepts the word this cycle |
| out_data | output | 16 | Current word of the consume buffer |
| conflict_count | output | 16 | Number of same-bank address steps served so far |

## Verification
A wrong generator state or a wrong conflict decision changes the gathered order. The word that disagrees shows up on `out_data` as soon as its buffer is presented, at most two buffers after the fault. Wrong fill or read counts appear as early or late edges of `out_valid`: in the first-valid cycle, and in the one-cycle gap between buffers under a slow consumer. A stall that is not obeyed shows up as a `conflict_count` that keeps moving while the consumer is idle.

// File: rtl/rga_pingpong_gather.sv
module rga_pingpong_gather #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int DEPTH = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic [15:0]   conflict_count
);
  localparam int NB = 1 << AW;
  localparam int IW = $clog2(DEPTH);
  localparam int CW = IW + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);
  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  function automatic logic [DW-1:0] mem_word(input logic [AW:0] a);
    return DW'((32'(a) * 32'h9E37) ^ 32'h5A5A);
  endfunction

  logic [15:0]   lfsr;
  logic          pend, fsel, cact;
  logic [CW-1:0] wcnt;
  logic [IW-1:0] rcnt;
  logic [DW-1:0] bank [2][NB];
  logic [DW-1:0] pbuf [2][DEPTH];

  wire [AW:0]    a0    = lfsr[AW:0];
  wire [AW:0]    a1    = lfsr[15 -: AW+1];
  wire           same  = a0[0] == a1[0];
  wire           fill  = wcnt != FULL;
  wire [AW:0]    ap    = pend ? a1 : a0;
  wire [DW-1:0]  dp    = bank[ap[0]][ap[AW:1]];
  wire [DW-1:0]  ds    = bank[a1[0]][a1[AW:1]];
  wire           dual  = !pend && !same;
  wire           take  = out_valid && out_ready;
  wire           swap  = !fill && !cact;
  wire [15:0]    lnext = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  wire [IW-1:0]  wi    = wcnt[IW-1:0];
  wire [IW-1:0]  wi1   = wi + IW'(1);

  assign out_valid = cact;
  assign out_data  = pbuf[~fsel][rcnt];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr <= SEED;
      pend <= 1'b0;
      fsel <= 1'b0;
      cact <= 1'b0;
      wcnt <= '0;
      rcnt <= '0;
      conflict_count <= '0;
      for (int b = 0; b < 2; b++)
        for (int i = 0; i < NB; i++)
          bank[b][i] <= mem_word((AW+1)'(i * 2 + b));
    end else begin
      if (fill) begin
        wcnt <= wcnt + CW'(dual ? 2 : 1);
        pend <= !pend && same;
        if (!pend && same) conflict_count <= conflict_count + 16'd1;
        if (pend || !same) lfsr <= lnext;
      end
      if (take) begin
        rcnt <= rcnt + IW'(1);
        if (rcnt == LAST) cact <= 1'b0;
      end
      if (swap) begin
        fsel <= ~fsel;
        wcnt <= '0;
        rcnt <= '0;
        cact <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && fill) begin
      pbuf[fsel][wi] <= dp;
      if (dual) pbuf[fsel][wi1] <= ds;
    end
  end

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  a_r6_drop_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(take));

  a_r6_rise_after_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(wcnt == FULL));

  a_r4_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (conflict_count == $past(conflict_count)) ||
    (conflict_count == $past(conflict_count) + 16'd1));

  a_r3_serialize: assert property (@(posedge clk) disable iff (!rst_n)
    fill && !pend && same |=> pend && $stable(lfsr));

  a_r7_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= FULL);
endmodule

// File: tb/sim_rga_pingpong_gather.sv
module sim_rga_pingpong_gather;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 48;
  localparam int NW = NP * 2;
  localparam int NBUF = 8;
  localparam int DLY [NBUF] = '{0, 2, 0, 1, 5, 0, 3, 1};

  logic clk = 1'b0, rst_n = 1'b0, out_ready = 1'b0;
  logic out_valid;
  logic [15:0] out_data, conflict_count;
  int checks = 0, errors = 0, widx = 0;
  logic [15:0] expw [NW];
  int pc [NP];
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rga_pingpong_gather u0 (
    .clk(clk), .rst_n(rst_n), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .conflict_count(conflict_count)
  );

  function automatic logic [15:0] mw(input int a);
    return 16'((32'(a) * 32'h9E37) ^ 32'h5A5A);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic take_word(input int d);
    repeat (d) @(negedge clk);
    while (!out_valid) @(negedge clk);
    chk(out_data == expw[widx], "R5 R3 R1 R2 word order", out_data, expw[widx]);
    widx++;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  initial begin
    logic [15:0] l;
    int c;
    l = 16'hACE1;
    c = 0;
    for (int p = 0; p < NP; p++) begin
      int a0, a1;
      a0 = int'(l[4:0]);
      a1 = int'(l[15:11]);
      if (a0[0] == a1[0]) c++;
      pc[p] = c;
      expw[2*p] = mw(a0);
      expw[2*p+1] = mw(a1);
      l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    end
  end

  initial begin
    int n;
    logic [15:0] held;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R10 valid in reset", out_valid, 0);
    chk(conflict_count == 16'd0, "R10 count in reset", conflict_count, 0);
    rst_n = 1'b1;
    n = 0;
    for (int k = 1; k <= 40; k++) begin
      @(negedge clk);
      if (out_valid) begin n = k; break; end
    end
    chk(n == 4 + pc[3] + 1, "R6 first valid cycle", n, 4 + pc[3] + 1);

    held = out_data;
    repeat (40) @(negedge clk);
    chk(out_valid == 1'b1 && out_data == held, "R8 hold under backpressure", out_data, held);
    chk(conflict_count == 16'(pc[7]), "R4 R7 count frozen while both full", conflict_count, pc[7]);

    for (int b = 0; b < NBUF; b++) begin
      for (int j = 0; j < 8; j++) take_word(DLY[b]);
      if (DLY[b] >= 2) begin
        chk(out_valid == 1'b0, "R6 valid drops after drain", out_valid, 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R9 next buffer one cycle later", out_valid, 1);
      end
    end

    repeat (40) @(negedge clk);
    chk(conflict_count == 16'(pc[4*(NBUF+2)-1]), "R4 R7 count after run",
        conflict_count, pc[4*(NBUF+2)-1]);
    chk(out_valid == 1'b1 && out_data == expw[8*NBUF], "R5 next buffer head",
        out_data, expw[8*NBUF]);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", widx, 8 * NBUF);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule